// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

This block is an eight-pin general-purpose I/O port. It has a 32-bit register interface on a plain read/write bus with an address, write data, a write strobe, a read strobe and read data. Pin state is reached through a 1 KB window. In that window, address bits [9:2] form a per-pin select mask. Software can therefore set, clear or sample any group of pins with a single access, and needs no read-modify-write.

The block also holds a direction register and an alternate-function select register, and it answers a read-only identification area. The direction register drives the output-enable bus. The data register drives the output-value bus. For pins configured as inputs, the data register captures the synchronized external pin level on every clock. The alternate-function select value is only presented on a port: the muxing itself, the pads and any interrupt detection live in other blocks.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction, alternate-select and data registers are zero, so all pins are inputs and `rd_data` is zero.
- R2: A write at offset 0x400 stores the low 8 bits of `wr_data` as the direction register (1 = output). A read there returns those 8 bits with the upper bits zero.
- R3: A write at offset 0x420 stores the low 8 bits of `wr_data` as the alternate-function select. A read returns them, and `alt_sel` shows them.
- R4: A write at any offset below 0x400 updates data bit i only when address bit (i+2) is 1 and direction bit i is 1. Every other data bit keeps its value, or keeps following its input.
- R5: A read at any offset below 0x400 returns data bit i only where address bit (i+2) is 1. Unselected bits and bits 31:8 read as 0.
- R6: For a pin whose direction bit is 0, the data register bit takes the value of `pin_in` within three clock cycles, through a two-stage synchronizer.
- R7: Reads at 0xFE0 + 4k (k = 0..7) return the byte 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for k = 0..7 respectively, in bits 7:0 with the upper bits zero. Writes there change nothing.
- R8: Reads at any other offset (for example 0x404) return 0. Writes there leave every register unchanged.
- R9: `pin_oe` always equals the direction register, and `pin_out` always equals the data register.
- R10: `rd_data` is registered. It takes the addressed value at the clock edge where `rd_en` is high and holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Output value for each pin |
| pin_oe | output | 8 | Output enable for each pin |
| alt_sel | output | 8 | Alternate-function select for each pin |

## Verification
The masked data window is tried with several masks:
- the full mask 0xFF, to show plain storage;
- a single-bit mask, to show that only that pin is written;
- two-bit masks at different positions, to show that reads zero the unselected pins;
- a mask that covers only input pins, to show that the direction gates writes.

Input pins are then driven with a pattern that differs from the output bits, which separates resampled input bits from stored output bits. The identification bytes are read at the first, middle and last words, to tell their order from a shifted or reversed table. Writes to the identification area and to an unmapped offset are followed by readback of every register, to show that nothing changed.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   localparam logic [11:0] OFF_DIR     = 12'h400;
   localparam logic [11:0] OFF_ALT     = 12'h420;
   localparam logic [6:0]  ID_PAGE     = 7'h7F;   // 0xFE0..0xFFF

   typedef enum logic [2:0] {
      RG_DATA,
      RG_DIR,
      RG_ALT,
      RG_ID,
      RG_NONE
   } region_e;

   // Map a 12-bit byte offset to the register region it selects.
   function automatic region_e gpm_decode(input logic [11:0] a);
      region_e r;
      if (a[11:10] == 2'b00)                         r = RG_DATA;
      else if (a == OFF_DIR)                         r = RG_DIR;
      else if (a == OFF_ALT)                         r = RG_ALT;
      else if (a[11:5] == ID_PAGE && a[1:0] == 2'b00) r = RG_ID;
      else                                           r = RG_NONE;
      return r;
   endfunction

   // Identification byte for word index k of the read-only area.
   function automatic logic [7:0] gpm_id_byte(input logic [2:0] k);
      logic [7:0] b;
      case (k)
         3'd0:    b = 8'h61;
         3'd1:    b = 8'h10;
         3'd2:    b = 8'h14;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_chk_stages
      $error("gpio_mask_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs
   import gpio_mask_pkg::*;
#(
   parameter int unsigned PINS   = 8,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [PINS-1:0]   pin_sync,
   output logic [PINS-1:0]   dir_q,
   output logic [PINS-1:0]   alt_q,
   output logic [PINS-1:0]   data_q
);

   localparam int unsigned MSK_LO = 2;
   localparam int unsigned MSK_HI = MSK_LO + PINS - 1;

   region_e         wr_region;
   logic            wr_hit_data;
   logic [PINS-1:0] sel_mask;
   logic [PINS-1:0] wr_allow;
   logic [PINS-1:0] data_nxt;

   assign wr_region   = gpm_decode(addr[11:0]);
   assign wr_hit_data = wr_en && (wr_region == RG_DATA);
   assign sel_mask    = addr[MSK_HI:MSK_LO];
   assign wr_allow    = wr_hit_data ? (sel_mask & dir_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         alt_q <= '0;
      end else if (wr_en) begin
         if (wr_region == RG_DIR) dir_q <= wr_data[PINS-1:0];
         if (wr_region == RG_ALT) alt_q <= wr_data[PINS-1:0];
      end
   end

   // Per pin: output bits hold or take a masked write, input bits resample.
   for (genvar i = 0; i < PINS; i++) begin : g_bit
      assign data_nxt[i] = !dir_q[i]   ? pin_sync[i] :
                           wr_allow[i] ? wr_data[i]  : data_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= data_nxt;
   end

   // R4: output bits outside the permitted write set do not move
   a_r4_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_allow)) == '0);

   // R4: permitted bits take the written value
   a_r4_write_applied: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hit_data) |->
         ((data_q ^ $past(wr_data[PINS-1:0])) & $past(wr_allow)) == '0);

   // R2: direction changes only on a write at its offset
   a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && wr_region == RG_DIR) |-> $stable(dir_q));

   // R3: alternate select changes only on a write at its offset
   a_r3_alt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && wr_region == RG_ALT) |-> $stable(alt_q));

endmodule

// File: rtl/gpio_mask_rdmux.sv
module gpio_mask_rdmux
   import gpio_mask_pkg::*;
#(
   parameter int unsigned PINS   = 8,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PINS-1:0]   dir_q,
   input  logic [PINS-1:0]   alt_q,
   input  logic [PINS-1:0]   data_q,
   output logic [BUS_W-1:0]  rd_data
);

   localparam int unsigned MSK_LO = 2;
   localparam int unsigned MSK_HI = MSK_LO + PINS - 1;

   region_e          rd_region;
   logic [PINS-1:0]  rd_mask;
   logic [BUS_W-1:0] rd_val;

   assign rd_region = gpm_decode(addr[11:0]);
   assign rd_mask   = addr[MSK_HI:MSK_LO];

   always_comb begin
      rd_val = '0;
      case (rd_region)
         RG_DATA: rd_val[PINS-1:0] = data_q & rd_mask;
         RG_DIR:  rd_val[PINS-1:0] = dir_q;
         RG_ALT:  rd_val[PINS-1:0] = alt_q;
         RG_ID:   rd_val[7:0]      = gpm_id_byte(addr[4:2]);
         default: rd_val           = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_val;
   end

   // R10: read data holds while no read is strobed
   a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(rd_data));

   // R5: unselected pins of a data-window read return zero
   a_r5_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && rd_region == RG_DATA) |->
         (rd_data[PINS-1:0] & ~$past(rd_mask)) == '0);

   // R8: unmapped offsets read as zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && rd_region == RG_NONE) |-> rd_data == '0);

   // R7: identification words carry one byte only
   a_r7_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && rd_region == RG_ID) |-> rd_data[BUS_W-1:8] == '0);

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
   parameter int unsigned PINS        = 8,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [BUS_W-1:0]  rd_data,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   alt_sel
);

   if (PINS != 8) begin : g_chk_pins
      $error("gpio_mask_port: the address mask field fixes PINS at 8");
   end
   if (ADDR_W != 12) begin : g_chk_addr
      $error("gpio_mask_port: ADDR_W must be 12");
   end
   if (BUS_W < 8) begin : g_chk_bus
      $error("gpio_mask_port: BUS_W must hold an identification byte");
   end

   logic [PINS-1:0] pin_sync;
   logic [PINS-1:0] dir_q;
   logic [PINS-1:0] alt_q;
   logic [PINS-1:0] data_q;

   gpio_mask_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_mask_regs #(.PINS(PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .pin_sync (pin_sync),
      .dir_q    (dir_q),
      .alt_q    (alt_q),
      .data_q   (data_q)
   );

   gpio_mask_rdmux #(.PINS(PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .addr    (addr),
      .dir_q   (dir_q),
      .alt_q   (alt_q),
      .data_q  (data_q),
      .rd_data (rd_data)
   );

   assign pin_out = data_q;
   assign pin_oe  = dir_q;
   assign alt_sel = alt_q;

   // R1: control outputs are zero in the first cycle after reset
   a_r1_reset_zero: assert property (@(posedge clk)
      $past(!rst_n) |-> (pin_oe == '0 && alt_sel == '0 && rd_data == '0));

endmodule

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out, pin_oe, alt_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_mask_port dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .alt_sel(alt_sel)
   );

   // op(2) req(4) addr(12) wdata(32) expect(32); op 1 = write, 2 = read
   localparam int NV = 24;
   localparam logic [81:0] VEC [NV] = '{
      {2'd1, 4'd2, 12'h400, 32'hFFFFFF0F, 32'h0},        // R2 write dir
      {2'd2, 4'd2, 12'h400, 32'h0,        32'h0F},       // R2 readback
      {2'd1, 4'd4, 12'h3FC, 32'hFF,       32'h0},        // R4 full mask
      {2'd2, 4'd5, 12'h3FC, 32'h0,        32'h0F},       // R5
      {2'd1, 4'd4, 12'h004, 32'h0,        32'h0},        // R4 clear pin 0
      {2'd2, 4'd5, 12'h3FC, 32'h0,        32'h0E},       // R5
      {2'd2, 4'd5, 12'h018, 32'h0,        32'h06},       // R5 mask 06
      {2'd2, 4'd5, 12'h020, 32'h0,        32'h08},       // R5 mask 08
      {2'd1, 4'd4, 12'h0C0, 32'hFF,       32'h0},        // R4 input pins only
      {2'd2, 4'd4, 12'h3FC, 32'h0,        32'h0E},       // R4 unchanged
      {2'd1, 4'd3, 12'h420, 32'h1A5,      32'h0},        // R3
      {2'd2, 4'd3, 12'h420, 32'h0,        32'hA5},       // R3
      {2'd2, 4'd7, 12'hFE0, 32'h0,        32'h61},       // R7
      {2'd2, 4'd7, 12'hFE4, 32'h0,        32'h10},       // R7
      {2'd2, 4'd7, 12'hFEC, 32'h0,        32'h00},       // R7
      {2'd2, 4'd7, 12'hFF0, 32'h0,        32'h0D},       // R7
      {2'd2, 4'd7, 12'hFFC, 32'h0,        32'hB1},       // R7
      {2'd1, 4'd7, 12'hFE0, 32'h55,       32'h0},        // R7 write ignored
      {2'd2, 4'd7, 12'hFE0, 32'h0,        32'h61},       // R7
      {2'd1, 4'd8, 12'h404, 32'hFF,       32'h0},        // R8 unmapped write
      {2'd2, 4'd8, 12'h404, 32'h0,        32'h0},        // R8 reads zero
      {2'd2, 4'd8, 12'h3FC, 32'h0,        32'h0E},       // R8 data intact
      {2'd2, 4'd8, 12'h400, 32'h0,        32'h0F},       // R8 dir intact
      {2'd2, 4'd8, 12'h420, 32'h0,        32'hA5}        // R8 alt intact
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
      check("R1 pin_out", {24'h0, pin_out}, 32'h0);
      check("R1 alt_sel", {24'h0, alt_sel}, 32'h0);
      check("R1 rd_data", rd_data, 32'h0);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][81:80] == 2'd1) do_write(VEC[k][75:64], VEC[k][63:32]);
         else begin
            do_read(VEC[k][75:64], v);
            check($sformatf("R%0d vec %0d", VEC[k][79:76], k), v, VEC[k][31:0]);
         end
      end

      // R9 output buses mirror registers; R3 port
      check("R9 pin_out", {24'h0, pin_out}, 32'h0E);
      check("R9 pin_oe", {24'h0, pin_oe}, 32'h0F);
      check("R3 alt_sel", {24'h0, alt_sel}, 32'hA5);

      // R6 input pins follow pin_in
      pin_in = 8'hF0;
      repeat (4) @(negedge clk);
      do_read(12'h3FC, v);
      check("R6 inputs sampled", v, 32'hFE);
      do_read(12'h0C0, v);
      check("R6 R5 masked input", v, 32'h30);
      check("R9 pin_out inputs", {24'h0, pin_out}, 32'hFE);

      // R4 all inputs: writes have no effect, bits follow pins
      do_write(12'h400, 32'h0);
      repeat (4) @(negedge clk);
      do_write(12'h3FC, 32'h0F);
      do_read(12'h3FC, v);
      check("R4 dir zero blocks write", v, 32'hF0);

      // R10 rd_data holds without rd_en
      @(negedge clk);
      addr = 12'h420;
      repeat (2) @(negedge clk);
      check("R10 hold", rd_data, 32'hF0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule